// File: doc/BRIEF.md
# Three-Octave Pyramid Wavelet Decomposer

This block takes a stream of signed 13-bit samples and breaks it into three octaves of a one-dimensional discrete wavelet transform. Each octave runs two six-tap filters, a high-pass one that gives a detail band and a low-pass one that gives an approximation band, and keeps only every second result. The first octave works on the raw samples. The second octave works on the first octave's approximation stream, and the third octave works on the second octave's approximation stream. The outputs are the three detail bands and the last approximation band.

Every octave keeps its own six-entry history of its own decimated input. Samples before the first one after reset are taken as zero. A single multiply-accumulate datapath, shared over time, computes the results. Each result leaves on one output stream, tagged with its octave and band, in the order it becomes ready. Both streams use valid/ready handshakes. A sample is taken only when `in_valid` and `in_ready` are both high. `in_ready` stays low for as long as results caused by the previous sample are still waiting. While `out_valid` is high and `out_ready` is low, the result and its tags are held.

Top module: `pyr_dwt3`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. Every octave history holds zeros, so the first results use zero for all samples before index 0.
- R2: For each accepted input at an even index n (counted from 0 after reset), octave 1 emits b(n) = Σk g[k]·a(n−k) and c(n) = Σk h[k]·a(n−k), for k = 0..5. The high-pass taps are g = {−8, 20, −11, −3, 2, 1} and the low-pass taps are h = {1, −2, −3, 11, 20, 8}, listed for k = 0..5.
- R3: When n is a multiple of 4, octave 2 then emits d(n) = Σk g[k]·c(n−2k) and e(n) = Σk h[k]·c(n−2k).
- R4: When n is a multiple of 8, octave 3 then emits f(n) = Σk g[k]·e(n−4k) and gg(n) = Σk h[k]·e(n−4k).
- R5: The results of one input leave in rising octave order. Within an octave the detail comes before the approximation, and no other result comes between the two.
- R6: For an input of N samples, with N a multiple of 8, each band of octave 1 carries N/2 results, each band of octave 2 carries N/4 and each band of octave 3 carries N/8.
- R7: `in_ready` is 0 whenever `out_valid` is 1. No sample is taken unless `in_valid` and `in_ready` are both 1. Idle cycles have no effect on the results.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_octave` and `out_band` keep their values on the next cycle.
- R9: Results are exact two's-complement values for any 13-bit input, with no wraparound. An octave-1 result fits in 19 signed bits, an octave-2 result in 25 bits and an octave-3 result in 31 bits.
- R10: `out_octave` is 1, 2 or 3 whenever `out_valid` is 1. `out_band` is 0 for a detail band and 1 for an approximation band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 13 | Signed input sample |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 31 | Signed result |
| out_octave | output | 2 | Octave of the result, 1 to 3 |
| out_band | output | 1 | 0 = detail, 1 = approximation |

## Verification
A corrupted history entry goes wrong at the ports on the next result of that octave. The error stays visible for up to five more results of the same octave, and it spreads into every later approximation that depends on it. A decimation phase that has slipped moves results off the even, multiple-of-4 or multiple-of-8 grid, which breaks the tag sequence and the per-band counts from the first affected sample onward. A sequencing fault, such as a skipped band, a swapped order or a dropped stall, shows at once as a tag mismatch or as changed data during back-pressure.

// File: rtl/dwt3_pkg.sv
package dwt3_pkg;

  localparam int TAPS   = 6;
  localparam int LEVELS = 3;
  localparam int COEF_W = 8;

  typedef enum logic {ST_IDLE = 1'b0, ST_OUT = 1'b1} seq_state_e;

  // band 0: high-pass (detail), band 1: low-pass (approximation)
  function automatic logic signed [COEF_W-1:0] tap_coef(input logic band, input int k);
    logic signed [COEF_W-1:0] c;
    c = '0;
    if (band) begin
      case (k)
        0: c = 8'sd1;
        1: c = -8'sd2;
        2: c = -8'sd3;
        3: c = 8'sd11;
        4: c = 8'sd20;
        default: c = 8'sd8;
      endcase
    end else begin
      case (k)
        0: c = -8'sd8;
        1: c = 8'sd20;
        2: c = -8'sd11;
        3: c = -8'sd3;
        4: c = 8'sd2;
        default: c = 8'sd1;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/dwt3_hist.sv
module dwt3_hist
  import dwt3_pkg::*;
#(
  parameter int W     = 31,
  parameter int DEPTH = TAPS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [W-1:0]                din,
  output logic [DEPTH-1:0][W-1:0]     taps
);

  // taps[0] is the newest sample of this octave's input stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (push) begin
      taps[0] <= din;
      for (int i = 1; i < DEPTH; i++) begin
        taps[i] <= taps[i-1];
      end
    end
  end

endmodule

// File: rtl/dwt3_mac.sv
module dwt3_mac
  import dwt3_pkg::*;
#(
  parameter int W = 31
) (
  input  logic [TAPS-1:0][W-1:0] taps,
  input  logic                   band,
  output logic [W-1:0]           y
);

  logic signed [W-1:0] cext [TAPS];

  genvar gk;
  generate
    for (gk = 0; gk < TAPS; gk++) begin : g_coef
      assign cext[gk] = W'(tap_coef(band, gk));
    end
  endgenerate

  // guard bits in W keep every partial sum in range
  always_comb begin
    logic signed [W-1:0] acc;
    acc = '0;
    for (int k = 0; k < TAPS; k++) begin
      acc = acc + $signed(taps[k]) * cext[k];
    end
    y = acc;
  end

endmodule

// File: rtl/dwt3_seq.sv
module dwt3_seq
  import dwt3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic [1:0]        lvl,
  output logic              band,
  output logic [LEVELS-1:0] push
);

  seq_state_e        st_q, st_d;
  logic [1:0]        lvl_d;
  logic              band_d;
  logic [LEVELS-1:0] ph_q;   // 0: next input of that octave triggers a result

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_OUT);

  always_comb begin
    st_d   = st_q;
    lvl_d  = lvl;
    band_d = band;
    push   = '0;
    case (st_q)
      ST_IDLE: begin
        if (in_valid) begin
          push[0] = 1'b1;
          if (!ph_q[0]) begin
            st_d   = ST_OUT;
            lvl_d  = 2'd0;
            band_d = 1'b0;
          end
        end
      end
      default: begin
        if (out_ready) begin
          if (!band) begin
            band_d = 1'b1;
          end else begin
            st_d = ST_IDLE;
            case (lvl)
              2'd0: begin
                push[1] = 1'b1;
                if (!ph_q[1]) begin
                  st_d   = ST_OUT;
                  lvl_d  = 2'd1;
                  band_d = 1'b0;
                end
              end
              2'd1: begin
                push[2] = 1'b1;
                if (!ph_q[2]) begin
                  st_d   = ST_OUT;
                  lvl_d  = 2'd2;
                  band_d = 1'b0;
                end
              end
              default: st_d = ST_IDLE;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      lvl  <= '0;
      band <= 1'b0;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      lvl  <= lvl_d;
      band <= band_d;
      ph_q <= ph_q ^ push;
    end
  end

endmodule

// File: rtl/pyr_dwt3.sv
module pyr_dwt3
  import dwt3_pkg::*;
#(
  parameter int DATA_W  = 13,
  parameter int GUARD_W = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [DATA_W-1:0]                 in_data,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [DATA_W+LEVELS*GUARD_W-1:0]  out_data,
  output logic [1:0]                        out_octave,
  output logic                              out_band
);

  localparam int ACC_W = DATA_W + LEVELS * GUARD_W;

  logic [1:0]                  lvl;
  logic                        band;
  logic [LEVELS-1:0]           push;
  logic [ACC_W-1:0]            mac_y;
  logic [ACC_W-1:0]            hist_din [LEVELS];
  logic [TAPS-1:0][ACC_W-1:0]  hist_taps [LEVELS];
  logic [TAPS-1:0][ACC_W-1:0]  sel_taps;

  dwt3_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .lvl       (lvl),
    .band      (band),
    .push      (push)
  );

  genvar gl;
  generate
    for (gl = 0; gl < LEVELS; gl++) begin : g_lvl
      if (gl == 0) begin : g_raw
        assign hist_din[gl] = {{(ACC_W-DATA_W){in_data[DATA_W-1]}}, in_data};
      end else begin : g_casc
        // fed by the previous octave's approximation while it is handed out
        assign hist_din[gl] = mac_y;
      end
      dwt3_hist #(.W(ACC_W), .DEPTH(TAPS)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push[gl]),
        .din   (hist_din[gl]),
        .taps  (hist_taps[gl])
      );
    end
  endgenerate

  always_comb begin
    case (lvl)
      2'd1:    sel_taps = hist_taps[1];
      2'd2:    sel_taps = hist_taps[2];
      default: sel_taps = hist_taps[0];
    endcase
  end

  dwt3_mac #(.W(ACC_W)) u_mac (
    .taps (sel_taps),
    .band (band),
    .y    (mac_y)
  );

  assign out_data   = mac_y;
  assign out_octave = lvl + 2'd1;
  assign out_band   = band;

endmodule

// File: rtl/pyr_dwt3_chk.sv
module pyr_dwt3_chk #(
  parameter int DATA_W  = 13,
  parameter int GUARD_W = 6
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_ready,
  input logic                          out_valid,
  input logic                          out_ready,
  input logic [DATA_W+3*GUARD_W-1:0]   out_data,
  input logic [1:0]                    out_octave,
  input logic                          out_band
);

  localparam int ACC_W  = DATA_W + 3 * GUARD_W;
  localparam int L1_MSB = DATA_W + GUARD_W - 1;
  localparam int L2_MSB = DATA_W + 2 * GUARD_W - 1;

  logic l1_fits, l2_fits;
  assign l1_fits = (&out_data[ACC_W-1:L1_MSB]) || (~|out_data[ACC_W-1:L1_MSB]);
  assign l2_fits = (&out_data[ACC_W-1:L2_MSB]) || (~|out_data[ACC_W-1:L2_MSB]);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_octave) && $stable(out_band)); // R8
  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R7
  AST_OCT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_octave != 2'd0); // R10
  AST_BAND_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_band |=> out_valid && out_band && $stable(out_octave)); // R5
  AST_OCT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_band |=> in_ready || (out_octave == $past(out_octave) + 2'd1 && !out_band)); // R5
  AST_L1_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_octave == 2'd1 |-> l1_fits); // R9
  AST_L2_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_octave == 2'd2 |-> l2_fits); // R9

endmodule

bind pyr_dwt3 pyr_dwt3_chk #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_octave (out_octave),
  .out_band   (out_band)
);

// File: tb/pyr_dwt3_bench.sv
module pyr_dwt3_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 13;
  localparam int GUARD_W    = 6;
  localparam int ACC_W      = DATA_W + 3 * GUARD_W;
  localparam int NMAX       = 256;
  localparam int EMAX       = 1024;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [ACC_W-1:0]  out_data;
  logic [1:0]        out_octave;
  logic              out_band;

  pyr_dwt3 #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_pyr_dwt3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_octave(out_octave), .out_band(out_band)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int gtab [6] = '{-8, 20, -11, -3, 2, 1};
  int htab [6] = '{1, -2, -3, 11, 20, 8};

  int     a_s [NMAX];
  longint cv  [NMAX];
  longint ev  [NMAX];
  int     exp_oct [EMAX];
  int     exp_bnd [EMAX];
  longint exp_val [EMAX];
  int     exp_n, rd;
  int     n_chk = 0, n_bad = 0;
  int     cnt [4][2];
  bit     bp_mode = 0;
  bit     finished = 0;
  logic [15:0] bp_lfsr = 16'hACE1;

  logic             prev_stall = 1'b0;
  logic [ACC_W-1:0] prev_data;
  logic [1:0]       prev_oct;
  logic             prev_bnd;

  function automatic longint av(int j);
    return (j < 0) ? 0 : longint'(a_s[j]);
  endfunction
  function automatic longint cvv(int j);
    return (j < 0) ? 0 : cv[j];
  endfunction
  function automatic longint evv(int j);
    return (j < 0) ? 0 : ev[j];
  endfunction

  task automatic add_exp(int o, int b, longint v);
    exp_oct[exp_n] = o;
    exp_bnd[exp_n] = b;
    exp_val[exp_n] = v;
    exp_n++;
  endtask

  task automatic build_exp(int n);
    exp_n = 0;
    for (int i = 0; i < n; i++) begin
      if (i % 2 == 0) begin
        longint bs = 0, cs = 0;
        for (int k = 0; k < 6; k++) begin
          bs += gtab[k] * av(i - k);
          cs += htab[k] * av(i - k);
        end
        cv[i] = cs;
        add_exp(1, 0, bs); add_exp(1, 1, cs);
        if (i % 4 == 0) begin
          longint ds = 0, es = 0;
          for (int k = 0; k < 6; k++) begin
            ds += gtab[k] * cvv(i - 2*k);
            es += htab[k] * cvv(i - 2*k);
          end
          ev[i] = es;
          add_exp(2, 0, ds); add_exp(2, 1, es);
          if (i % 8 == 0) begin
            longint fs = 0, gs = 0;
            for (int k = 0; k < 6; k++) begin
              fs += gtab[k] * evv(i - 4*k);
              gs += htab[k] * evv(i - 4*k);
            end
            add_exp(3, 0, fs); add_exp(3, 1, gs);
          end
        end
      end
    end
  endtask

  // output ready pattern
  initial begin
    forever begin
      @(posedge clk); #1;
      bp_lfsr  = {bp_lfsr[14:0], bp_lfsr[15] ^ bp_lfsr[13] ^ bp_lfsr[12] ^ bp_lfsr[10]};
      out_ready = bp_mode ? (bp_lfsr[0] | bp_lfsr[3]) : 1'b1;
    end
  end

  // monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        n_chk++;
        if (!(out_valid && out_data == prev_data && out_octave == prev_oct && out_band == prev_bnd)) begin
          n_bad++;
          $display("FAIL R8 stall hold: got v=%0b d=%0h o=%0d b=%0d exp d=%0h o=%0d b=%0d",
                   out_valid, out_data, out_octave, out_band, prev_data, prev_oct, prev_bnd);
        end
      end
      if (out_valid) begin
        n_chk++;
        if (in_ready) begin
          n_bad++;
          $display("FAIL R7 in_ready=%0b while out_valid, exp 0", in_ready);
        end
      end
      if (out_valid && out_ready) begin
        n_chk++;
        if (rd >= exp_n) begin
          n_bad++;
          $display("FAIL R6 extra result o=%0d b=%0d d=%0d, exp none", out_octave, out_band,
                   longint'($signed(out_data)));
        end else if (int'(out_octave) != exp_oct[rd] || int'(out_band) != exp_bnd[rd]) begin
          n_bad++;
          $display("FAIL R5/R10 tag #%0d: got o=%0d b=%0d exp o=%0d b=%0d", rd, out_octave,
                   out_band, exp_oct[rd], exp_bnd[rd]);
        end else if (longint'($signed(out_data)) != exp_val[rd]) begin
          n_bad++;
          $display("FAIL %s value #%0d (R9): got %0d exp %0d",
                   (exp_oct[rd] == 1) ? "R2" : (exp_oct[rd] == 2) ? "R3" : "R4",
                   rd, longint'($signed(out_data)), exp_val[rd]);
        end
        if (out_octave != 2'd0) cnt[out_octave][out_band]++;
        rd++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_oct   = out_octave;
      prev_bnd   = out_band;
    end else begin
      prev_stall = 1'b0;
    end
  end

  task automatic run_pat(int n, bit gaps, bit bp);
    build_exp(n);
    rd = 0;
    for (int o = 0; o < 4; o++) begin cnt[o][0] = 0; cnt[o][1] = 0; end
    bp_mode = bp;
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (!(in_ready && !out_valid)) begin   // R1 reset state
      n_bad++;
      $display("FAIL R1 reset: in_ready=%0b out_valid=%0b exp 1/0", in_ready, out_valid);
    end
    @(posedge clk); #1;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = DATA_W'(a_s[i]);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_data  = 13'h0AAA;   // idle garbage must be ignored (R7)
      if (gaps && ((i * 7) % 5 == 0)) begin
        repeat ((i % 3) + 1) @(posedge clk);
        #1;
      end
    end
    for (int t = 0; t < 4000 && rd < exp_n; t++) @(negedge clk);
    repeat (6) @(negedge clk);
    n_chk++;
    if (rd != exp_n) begin
      n_bad++;
      $display("FAIL R6 result total: got %0d exp %0d", rd, exp_n);
    end
    for (int o = 1; o <= 3; o++) begin
      for (int b = 0; b < 2; b++) begin
        int e = n >> o;
        n_chk++;
        if (cnt[o][b] != e) begin
          n_bad++;
          $display("FAIL R6 count octave %0d band %0d: got %0d exp %0d", o, b, cnt[o][b], e);
        end
      end
    end
  endtask

  initial begin
    logic [15:0] dl;
    // impulse sweep: one full-scale sample at each position (R1, R2, R3, R4)
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 32; i++) a_s[i] = (i == p) ? ((p % 2) ? -4096 : 4095) : 0;
      run_pat(32, p[0], p[1]);
    end
    // constant full-scale positive and negative (R9)
    for (int i = 0; i < 64; i++) a_s[i] = 4095;
    run_pat(64, 1'b0, 1'b1);
    for (int i = 0; i < 64; i++) a_s[i] = -4096;
    run_pat(64, 1'b1, 1'b0);
    // alternating extremes, worst case for the detail bands (R9)
    for (int i = 0; i < 64; i++) a_s[i] = (i % 2) ? -4096 : 4095;
    run_pat(64, 1'b1, 1'b1);
    // pattern of sign pairs, stresses deeper octaves (R3, R4)
    for (int i = 0; i < 64; i++) a_s[i] = ((i / 2) % 2) ? -4096 : 4095;
    run_pat(64, 1'b0, 1'b1);
    // ramp
    for (int i = 0; i < 64; i++) a_s[i] = i * 37 - 1200;
    run_pat(64, 1'b0, 1'b0);
    // pseudo-random, long, with stalls and gaps (R5, R7, R8)
    dl = 16'h1D2B;
    for (int i = 0; i < 128; i++) begin
      dl = {dl[14:0], dl[15] ^ dl[13] ^ dl[12] ^ dl[10]};
      a_s[i] = int'($signed(dl[12:0]));
    end
    run_pat(128, 1'b1, 1'b1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired: got hang exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule